// File: doc/BRIEF.md
# Bus Cycle Response Monitor

This block watches the processor's bus cycles and raises a one-clock bus-error pulse when a cycle goes unanswered for too long. A cycle begins with a start strobe that also carries its kind (ordinary data transfer or interrupt acknowledge), whether it targets the external bus, and whether the CPU started it. From the clock after the start, the block counts clocks until a valid acknowledge arrives, the cycle end strobe is seen, or the count reaches the limit chosen by a 2-bit timeout field.

In an ordinary cycle only the data acknowledge is a valid answer. In an interrupt-acknowledge cycle the autovector input is accepted as well. Interrupt-acknowledge cycles also have a short arbitration window at their start. If no arbitration is reported inside that window, the block flags a spurious interrupt. External cycles are timed only when the CPU started them and the external-monitoring enable is set. A 2-bit cause output reports why the last bus error happened. It holds that value until the next cycle starts.

Top module: `bus_resp_mon`

## Requirements
- R1: After reset, `berr` is 0, `cause` is 00, and the timeout field is 00.
- R2: The timeout field selects the limit LIM: 64, 32, 16 or 8 clocks for the codes 00, 01, 10 and 11. The start strobe is sampled at edge 0. If no valid answer is sampled at edges 1 to LIM, `berr` is high for the clock after edge LIM.
- R3: In an ordinary cycle (`cyc_iack`=0) only `dack` ends the timing. `avec` has no effect.
- R4: In an interrupt-acknowledge cycle, either `dack` or `avec` ends the timing.
- R5: An answer sampled at edge LIM still prevents the error. `berr` is never high for two clocks in a row.
- R6: An external cycle (`cyc_ext`=1) that the CPU did not start (`cyc_cpu`=0) is never timed out.
- R7: An external cycle started by the CPU is timed only when `ext_mon_en` is 1. Internal cycles are always timed.
- R8: In an interrupt-acknowledge cycle, if `arb_done` is not sampled at any of edges 1 to ARB_WIN (default 4) and no answer has ended the cycle, `berr` pulses after edge ARB_WIN with cause 10. This check is made before the timeout check.
- R9: `cause` becomes 01 on a timeout and 10 on a spurious interrupt. It holds that value until the next start strobe, which clears it to 00.
- R10: A `cyc_end` sampled while a cycle is being timed stops the timing without an error.
- R11: The limit is captured at the start strobe. Writing the field (`tmo_wr`, `tmo_wdata`) during a cycle affects only later cycles.
- R12: A start strobe during a timed cycle restarts timing from that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_iack | input | 1 | 1 = interrupt-acknowledge cycle, sampled with the start strobe |
| cyc_ext | input | 1 | 1 = cycle targets the external bus |
| cyc_cpu | input | 1 | 1 = cycle started by the CPU |
| cyc_end | input | 1 | Cycle terminated by other means |
| dack | input | 1 | Data acknowledge |
| avec | input | 1 | Autovector response |
| arb_done | input | 1 | Interrupt arbitration took place |
| ext_mon_en | input | 1 | Enable timing of CPU-started external cycles |
| tmo_wr | input | 1 | Write strobe for the timeout field |
| tmo_wdata | input | 2 | New timeout field value |
| berr | output | 1 | Bus-error pulse |
| cause | output | 2 | Last error cause: 00 none, 01 timeout, 10 spurious |

## Verification
Some properties are checked on every clock by the assertions. `berr` is a single-clock pulse and always comes with a nonzero cause. A start clears both outputs on the next clock. A timeout fires only when the captured limit has been reached. A spurious error needs an interrupt-acknowledge cycle with no arbitration seen. An ordinary cycle answered by `dack` raises no error. Other behaviour only the bench scenarios can show: the exact edge on which the error lands for each field code, `avec` being ignored in ordinary cycles, the external-cycle filtering, a field write mid-cycle, and a restart mid-cycle.

// File: rtl/bus_resp_mon.sv
module bus_resp_mon #(
  parameter int LIM_0   = 64,
  parameter int LIM_1   = 32,
  parameter int LIM_2   = 16,
  parameter int LIM_3   = 8,
  parameter int ARB_WIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_start,
  input  logic       cyc_iack,
  input  logic       cyc_ext,
  input  logic       cyc_cpu,
  input  logic       cyc_end,
  input  logic       dack,
  input  logic       avec,
  input  logic       arb_done,
  input  logic       ext_mon_en,
  input  logic       tmo_wr,
  input  logic [1:0] tmo_wdata,
  output logic       berr,
  output logic [1:0] cause
);

  localparam int CW = $clog2(LIM_0);
  localparam logic [1:0] C_TMO  = 2'b01;
  localparam logic [1:0] C_SPUR = 2'b10;

  logic [1:0]    field;
  logic [CW-1:0] cnt, lim_m1, lim_sel;
  logic          active, iack_q, arb_seen;

  wire monitored = !cyc_ext || (cyc_cpu && ext_mon_en);
  wire ack_ok    = dack || (iack_q && avec);
  wire spur_hit  = iack_q && !arb_seen && !arb_done && (cnt == CW'(ARB_WIN - 1));
  wire tmo_hit   = (cnt == lim_m1);

  always_comb begin
    case (field)
      2'b00:   lim_sel = CW'(LIM_0 - 1);
      2'b01:   lim_sel = CW'(LIM_1 - 1);
      2'b10:   lim_sel = CW'(LIM_2 - 1);
      default: lim_sel = CW'(LIM_3 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field    <= 2'b00;
      cnt      <= '0;
      lim_m1   <= '0;
      active   <= 1'b0;
      iack_q   <= 1'b0;
      arb_seen <= 1'b0;
      berr     <= 1'b0;
      cause    <= 2'b00;
    end else begin
      berr <= 1'b0;
      if (tmo_wr) field <= tmo_wdata;
      if (cyc_start) begin
        active   <= monitored;
        iack_q   <= cyc_iack;
        cnt      <= '0;
        arb_seen <= 1'b0;
        lim_m1   <= lim_sel;
        cause    <= 2'b00;
      end else if (active) begin
        if (cyc_end || ack_ok) begin
          active <= 1'b0;
        end else if (spur_hit) begin
          active <= 1'b0;
          berr   <= 1'b1;
          cause  <= C_SPUR;
        end else if (tmo_hit) begin
          active <= 1'b0;
          berr   <= 1'b1;
          cause  <= C_TMO;
        end else begin
          cnt <= cnt + 1'b1;
          if (arb_done) arb_seen <= 1'b1;
        end
      end
    end
  end

  initial assert (ARB_WIN >= 1 && LIM_0 >= LIM_1 && LIM_1 >= LIM_2 && LIM_2 >= LIM_3 && LIM_3 >= 1);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    berr |=> !berr);
  assert_cause_with_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    berr |-> (cause != 2'b00));
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (!berr && cause == 2'b00));
  assert_tmo_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (berr && cause == C_TMO) |-> ($past(cnt) == $past(lim_m1)));
  assert_spur_needs_iack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (berr && cause == C_SPUR) |-> ($past(iack_q) && !$past(arb_seen)));
  assert_unmonitored_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && cyc_ext && !cyc_cpu) |=> !active);
  assert_dack_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cyc_start && dack) |=> !berr);

endmodule

// File: tb/tb_bus_resp_mon.sv
module tb_bus_resp_mon;
  localparam int CLK_P = 10;
  localparam int ARBW  = 4;

  logic clk = 0, rst_n = 0;
  logic cyc_start = 0, cyc_iack = 0, cyc_ext = 0, cyc_cpu = 0, cyc_end = 0;
  logic dack = 0, avec = 0, arb_done = 0, ext_mon_en = 0, tmo_wr = 0;
  logic [1:0] tmo_wdata = 0;
  logic berr;
  logic [1:0] cause;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bus_resp_mon dut (.clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_iack(cyc_iack),
    .cyc_ext(cyc_ext), .cyc_cpu(cyc_cpu), .cyc_end(cyc_end), .dack(dack), .avec(avec),
    .arb_done(arb_done), .ext_mon_en(ext_mon_en), .tmo_wr(tmo_wr), .tmo_wdata(tmo_wdata),
    .berr(berr), .cause(cause));

  function automatic int lim_of(int sel);
    case (sel)
      0: return 64;
      1: return 32;
      2: return 16;
      default: return 8;
    endcase
  endfunction

  // returns expected error edge (0 = none); cause written to c
  function automatic int expect_err(bit iack, bit ext, bit cpu, bit en, int sel,
                                    int ack_e, bit ack_av, int arb_e, int end_e,
                                    output logic [1:0] c);
    int stop = 0;
    c = 2'b00;
    if (ext && !(cpu && en)) return 0;
    if (ack_e > 0 && (!ack_av || iack)) stop = ack_e;
    if (end_e > 0 && (stop == 0 || end_e < stop)) stop = end_e;
    if (iack && (arb_e == 0 || arb_e > ARBW) && (stop == 0 || stop > ARBW)) begin
      c = 2'b10; return ARBW;
    end
    if (stop == 0 || stop > lim_of(sel)) begin
      c = 2'b01; return lim_of(sel);
    end
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_sel(int sel);
    tmo_wr = 1; tmo_wdata = 2'(sel);
    @(posedge clk); @(negedge clk);
    tmo_wr = 0;
  endtask

  // one scenario; wr_sel: write field first; mid_sel/mid_e: field write during cycle; rst_e: restart edge
  task automatic run(string req, bit wr, bit iack, bit ext, bit cpu, bit en, int sel,
                     int ack_e, bit ack_av, int arb_e, int end_e,
                     int mid_e = 0, int mid_sel = 0, int rst_e = 0);
    logic [1:0] ec;
    int ee, first = 0, pulses = 0;
    if (wr) write_sel(sel);
    ext_mon_en = en;
    ee = expect_err(iack, ext, cpu, en, sel, ack_e, ack_av, arb_e, end_e, ec);
    if (rst_e > 0 && ee > rst_e) ee = rst_e + ee;
    cyc_start = 1; cyc_iack = iack; cyc_ext = ext; cyc_cpu = cpu;
    @(posedge clk); @(negedge clk);
    cyc_start = 0;
    chk(berr == 0 && cause == 2'b00, {req, " R9 start clears"}, {berr, cause}, 0);
    for (int k = 1; k <= 90; k++) begin
      dack = (k == ack_e) && !ack_av;
      avec = (k == ack_e) && ack_av;
      arb_done = (k == arb_e);
      cyc_end = (k == end_e);
      cyc_start = (k == rst_e);
      tmo_wr = (k == mid_e); tmo_wdata = 2'(mid_sel);
      @(posedge clk); @(negedge clk);
      if (berr) begin pulses++; if (first == 0) first = k; end
    end
    {dack, avec, arb_done, cyc_end, cyc_start, tmo_wr} = '0;
    chk(first == ee, {req, " error edge"}, first, ee);
    chk(pulses == (ee != 0), {req, " R5 pulse count"}, pulses, ee != 0);
    chk(cause == ec, {req, " R9 cause held"}, cause, ec);
  endtask

  initial begin
    int n = 0;
    while (!done) begin
      @(posedge clk); n++;
      if (n > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=0", n);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk(berr == 0 && cause == 0, "R1 reset outputs", {berr, cause}, 0);
    // R1: field defaults to 00 -> 64
    run("R1 R2 default field", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int s = 1; s < 4; s++) run("R2 limit", 1, 0, 0, 0, 0, s, 0, 0, 0, 0);
    run("R3 avec ignored normal", 1, 0, 0, 0, 0, 3, 3, 1, 0, 0);
    run("R3 dack ends normal", 1, 0, 0, 0, 0, 3, 5, 0, 0, 0);
    run("R4 avec ends iack", 1, 1, 0, 0, 0, 2, 6, 1, 2, 0);
    run("R4 dack ends iack", 1, 1, 0, 0, 0, 2, 9, 0, 1, 0);
    run("R5 ack on limit edge", 1, 0, 0, 0, 0, 3, 8, 0, 0, 0);
    run("R5 ack one late", 1, 0, 0, 0, 0, 3, 9, 0, 0, 0);
    run("R6 ext non-cpu", 1, 0, 1, 0, 1, 3, 0, 0, 0, 0);
    run("R7 ext cpu disabled", 1, 0, 1, 1, 0, 3, 0, 0, 0, 0);
    run("R7 ext cpu enabled", 1, 0, 1, 1, 1, 3, 0, 0, 0, 0);
    run("R8 spurious", 1, 1, 0, 0, 0, 1, 0, 0, 0, 0);
    run("R8 arb at window end", 1, 1, 0, 0, 0, 3, 0, 0, ARBW, 0);
    run("R8 arb too late", 1, 1, 0, 0, 0, 3, 0, 0, ARBW + 1, 0);
    run("R10 end stops", 1, 0, 0, 0, 0, 3, 0, 0, 0, 5);
    // R11: field 11 captured, rewritten to 00 at edge 2 -> still 8
    run("R11 field latched", 1, 0, 0, 0, 0, 3, 0, 0, 0, 0, 2, 0);
    // R11 follow-up: next cycle uses 00 -> 64
    run("R11 next cycle new field", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R12: restart at edge 5 -> error at 13
    run("R12 restart", 1, 0, 0, 0, 0, 3, 0, 0, 0, 0, 0, 0, 5);
    for (int i = 0; i < 40; i++) begin
      int sel = $urandom_range(0, 3);
      run("random", 1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), sel,
          $urandom_range(0, 70), 1'($urandom_range(0, 1)), $urandom_range(0, 6),
          ($urandom_range(0, 3) == 0) ? $urandom_range(1, 70) : 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule